// File: doc/BRIEF.md
# FM Clock/Data Pulse Separator

This block takes one frequency-modulated read-data pulse line and splits its pulses into two streams: separated clock pulses and separated data pulses. Each bit cell opens with a clock pulse. That pulse opens a data window whose length is counted in clock cycles. A pulse that arrives while the data window is open is a data pulse, and the cell then holds a one. A pulse that arrives outside the data window is the clock pulse of the next cell.

The data window has two lengths, and both come from input ports. The short length applies after a cell that held a data pulse. The long length applies after a cell that did not. A previous-bit flag makes this choice and changes only when a window closes. If a data pulse lands in the last cycle of its window, the window stays open for one more cycle so that the whole separated data pulse falls inside it. Each window close also emits the recovered bit with a one-cycle strobe.

The block has three named states. `ST_CLOCK_WIN` moves to `ST_DATA_WIN` when a pulse arrives (transition "open"). `ST_DATA_WIN` returns to `ST_CLOCK_WIN` when the timer expires with no pulse arriving (transition "close"). It moves to `ST_DATA_HOLD` when a pulse arrives in the expiry cycle (transition "extend"). `ST_DATA_HOLD` returns to `ST_CLOCK_WIN` in the next cycle that has no new pulse (transition "release").

Top module: `fmsep_top`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `clk_win` is 1 and `data_win`, `sep_clk`, `sep_data`, `bit_valid` and `bit_out` are 0. The previous-bit flag is cleared, so the first data window after reset uses `win_long`.
- R2: In every cycle exactly one of `clk_win` and `data_win` is high.
- R3: `rd_raw` passes through a two-flop synchronizer. Each rising edge produces exactly one single-cycle separated pulse. If `rd_raw` is first sampled high at clock edge k, that pulse is high in the cycle that starts at edge k+2. A level held high produces no further pulses.
- R4: A pulse that arrives while `clk_win` is high produces a `sep_clk` pulse and opens the data window. With no data pulse in the cell, `data_win` then stays high for `win_long` cycles if the previous cell held no data, or for `win_short` cycles if it did.
- R5: A pulse that arrives while `data_win` is high produces a `sep_data` pulse, and the cell's bit is recorded as 1.
- R6: A pulse detected in the last cycle of a data window extends that window by exactly one cycle. `data_win` is still high while the resulting `sep_data` pulse is high.
- R7: When a data window closes, `bit_valid` is high for one cycle, in the first cycle of the clock window. `bit_out` then shows 1 if the cell held a data pulse and 0 if it did not. The same value becomes the previous-bit flag.
- R8: A pulse that arrives after the data window has closed is taken as a clock pulse (`sep_clk`), not as data.
- R9: `sep_clk` and `sep_data` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_raw | input | 1 | Raw read-data pulse line (asynchronous) |
| win_short | input | CNT_W | Data-window length in cycles after a cell with data (0 treated as 1) |
| win_long | input | CNT_W | Data-window length in cycles after a cell without data (0 treated as 1) |
| sep_clk | output | 1 | Single-cycle separated clock pulse |
| sep_data | output | 1 | Single-cycle separated data pulse |
| clk_win | output | 1 | Clock window is open |
| data_win | output | 1 | Data window is open |
| bit_out | output | 1 | Last recovered bit |
| bit_valid | output | 1 | One-cycle strobe for `bit_out` at each window close |

## Verification
Two events can fall in the same cycle: the expiry of the data-window timer and the detection of a data pulse. The bench provokes this collision by raising the data pulse so that its synchronized edge lands exactly in the window's last counted cycle. It does so for both window lengths and after both previous-bit values. A correct result is a data window one cycle longer than programmed, one counted `sep_data` pulse, and a recovered bit of 1. A pulse one cycle later must instead come out as a clock pulse. Every four-cell bit pattern is swept under several pairs of short and long window lengths.

// File: rtl/fmsep_pkg.sv
package fmsep_pkg;
    typedef enum logic [1:0] {
        ST_CLOCK_WIN = 2'd0,
        ST_DATA_WIN  = 2'd1,
        ST_DATA_HOLD = 2'd2
    } sep_state_e;
endpackage

// File: rtl/fmsep_edge_sync.sv
module fmsep_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    output logic rise_o
);
    localparam int SH_W = SYNC_STAGES + 1;

    logic [SH_W-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[SH_W-2:0], raw_in};
    end

    // rising edge seen at the synchronizer output
    always_comb rise_o = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
endmodule

// File: rtl/fmsep_win_timer.sv
module fmsep_win_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold_clr,
    input  logic             start,
    input  logic [CNT_W-1:0] len,
    output logic             last_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
        end else if (hold_clr) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
        end else if (start) begin
            cnt_q  <= (len == '0) ? CNT_W'(1) : len;
            busy_q <= 1'b1;
        end else if (busy_q) begin
            if (cnt_q == CNT_W'(1)) busy_q <= 1'b0;
            else                    cnt_q  <= cnt_q - CNT_W'(1);
        end
    end

    // high during the final counted cycle of the window
    always_comb last_o = busy_q && (cnt_q == CNT_W'(1));
endmodule

// File: rtl/fmsep_top.sv
module fmsep_top
    import fmsep_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_raw,
    input  logic [CNT_W-1:0] win_short,
    input  logic [CNT_W-1:0] win_long,
    output logic             sep_clk,
    output logic             sep_data,
    output logic             clk_win,
    output logic             data_win,
    output logic             bit_out,
    output logic             bit_valid
);
    localparam int N_TMR = 2;   // index 0: long window, index 1: short window

    sep_state_e       state_q, state_d;
    logic             rise;
    logic             prev_q;
    logic             seen_q;
    logic [N_TMR-1:0] tmr_last;
    logic             win_end;
    logic             open_win;
    logic             data_hit;
    logic             close_cell;

    fmsep_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_in (rd_raw),
        .rise_o (rise)
    );

    for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
        localparam bit SEL_V = (g == 1);
        fmsep_win_timer #(.CNT_W(CNT_W)) u_tmr (
            .clk      (clk),
            .rst_n    (rst_n),
            .hold_clr (prev_q != SEL_V),
            .start    (open_win && (prev_q == SEL_V)),
            .len      (SEL_V ? win_short : win_long),
            .last_o   (tmr_last[g])
        );
    end

    // next-state logic
    always_comb begin
        win_end    = tmr_last[prev_q];
        open_win   = (state_q == ST_CLOCK_WIN) && rise;
        data_hit   = (state_q != ST_CLOCK_WIN) && rise;
        state_d    = state_q;
        close_cell = 1'b0;
        unique case (state_q)
            ST_CLOCK_WIN: begin
                if (rise) state_d = ST_DATA_WIN;              // open
            end
            ST_DATA_WIN: begin
                if (win_end) begin
                    if (rise) begin
                        state_d = ST_DATA_HOLD;               // extend
                    end else begin
                        state_d    = ST_CLOCK_WIN;            // close
                        close_cell = 1'b1;
                    end
                end
            end
            ST_DATA_HOLD: begin
                if (!rise) begin
                    state_d    = ST_CLOCK_WIN;                // release
                    close_cell = 1'b1;
                end
            end
            default: state_d = ST_CLOCK_WIN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_CLOCK_WIN;
        else        state_q <= state_d;
    end

    // registered pulses, data latch, previous-bit flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sep_clk   <= 1'b0;
            sep_data  <= 1'b0;
            seen_q    <= 1'b0;
            prev_q    <= 1'b0;
            bit_out   <= 1'b0;
            bit_valid <= 1'b0;
        end else begin
            sep_clk   <= open_win;
            sep_data  <= data_hit;
            bit_valid <= close_cell;
            if (open_win)      seen_q <= 1'b0;
            else if (data_hit) seen_q <= 1'b1;
            if (close_cell) begin
                prev_q  <= seen_q;
                bit_out <= seen_q;
            end
        end
    end

    // window outputs
    always_comb begin
        clk_win  = (state_q == ST_CLOCK_WIN);
        data_win = (state_q != ST_CLOCK_WIN);
    end
endmodule

// File: rtl/fmsep_chk.sv
module fmsep_chk (
    input logic clk,
    input logic rst_n,
    input logic sep_clk,
    input logic sep_data,
    input logic clk_win,
    input logic data_win,
    input logic bit_valid
);
    AST_WIN_EXCL: assert property (@(posedge clk) disable iff (!rst_n) clk_win != data_win); // R2
    AST_CLK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) sep_clk |=> !sep_clk); // R3
    AST_CLK_OPENS: assert property (@(posedge clk) disable iff (!rst_n) sep_clk |-> data_win); // R4
    AST_DATA_INSIDE: assert property (@(posedge clk) disable iff (!rst_n) sep_data |-> data_win); // R6
    AST_VALID_AT_CLOSE: assert property (@(posedge clk) disable iff (!rst_n) bit_valid |-> (clk_win && $past(data_win))); // R7
    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) bit_valid |=> !bit_valid); // R7
    AST_NO_DUAL: assert property (@(posedge clk) disable iff (!rst_n) !(sep_clk && sep_data)); // R9
endmodule

bind fmsep_top fmsep_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sep_clk   (sep_clk),
    .sep_data  (sep_data),
    .clk_win   (clk_win),
    .data_win  (data_win),
    .bit_valid (bit_valid)
);

// File: tb/fmsep_top_test.sv
module fmsep_top_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rd_raw = 1'b0;
    logic [7:0] win_short = 8'd4;
    logic [7:0] win_long = 8'd7;
    logic       sep_clk, sep_data, clk_win, data_win, bit_out, bit_valid;

    int checks = 0;
    int bad = 0;
    int n_clk = 0, n_data = 0, n_valid = 0, n_both = 0;
    int run = 0, last_run = 0;
    int last_bit = 0;
    int s_len, l_len, prev_exp;

    fmsep_top #(.CNT_W(8), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .rd_raw(rd_raw),
        .win_short(win_short), .win_long(win_long),
        .sep_clk(sep_clk), .sep_data(sep_data), .clk_win(clk_win),
        .data_win(data_win), .bit_out(bit_out), .bit_valid(bit_valid)
    );

    always #4 clk = ~clk;

    // output monitor, sampled mid-cycle
    always @(negedge clk) begin
        if (!rst_n) begin
            run = 0;
        end else begin
            n_clk  += int'(sep_clk);
            n_data += int'(sep_data);
            if (sep_clk && sep_data) n_both++;
            if (data_win) run++;
            else if (run != 0) begin
                last_run = run;
                run = 0;
            end
            if (bit_valid) begin
                n_valid++;
                last_bit = int'(bit_out);
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        rd_raw = 1'b0;
        repeat (3) @(negedge clk);
        chk(clk_win == 1'b1, "R1 clk_win", int'(clk_win), 1);
        chk(data_win == 1'b0, "R1 data_win", int'(data_win), 0);
        chk(!sep_clk && !sep_data, "R1 pulses", int'(sep_clk) + int'(sep_data), 0);
        chk(!bit_valid && !bit_out, "R1 bit", int'(bit_valid) + int'(bit_out), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(clk_win && !data_win && !bit_valid, "R1 after release", int'(clk_win), 1);
        repeat (3) @(negedge clk);
        prev_exp = 0;
    endtask

    // kind: 0 no data, 1 early data, 2 data at window end, 3 late pulse, 4 long level
    task automatic do_cell(input int kind);
        int w, c0, d0, v0, b0, exp_run, exp_bit, exp_clk;
        w  = (prev_exp != 0) ? s_len : l_len;
        c0 = n_clk; d0 = n_data; v0 = n_valid; b0 = n_both;
        @(negedge clk) rd_raw = 1'b1;                 // first sampled at E1
        @(negedge clk);
        @(negedge clk);                               // between E2 and E3
        chk(sep_clk == 1'b0, "R3 latency early", int'(sep_clk), 0);
        if (kind != 4) rd_raw = 1'b0;
        @(negedge clk);                               // between E3 and E4
        chk(sep_clk == 1'b1, "R3 latency", int'(sep_clk), 1);
        chk(data_win && !clk_win, "R2 window after clock", int'(data_win), 1);
        if (kind == 1) begin
            rd_raw = 1'b1;
            repeat (2) @(negedge clk);
            rd_raw = 1'b0;
        end else if (kind == 2 || kind == 3) begin
            repeat (w - ((kind == 2) ? 3 : 2)) @(negedge clk);
            rd_raw = 1'b1;
            repeat (2) @(negedge clk);
            rd_raw = 1'b0;
        end else if (kind == 4) begin
            repeat (w + 10) @(negedge clk);
            rd_raw = 1'b0;
        end
        repeat (w + l_len + 12) @(negedge clk);
        exp_bit = (kind == 1 || kind == 2) ? 1 : 0;
        exp_clk = (kind == 3) ? 2 : 1;
        exp_run = (kind == 2) ? w + 1 : ((kind == 3) ? l_len : w);
        if (kind == 2)
            chk(last_run == exp_run, "R6 extended window", last_run, exp_run);
        else if (kind == 3)
            chk(last_run == exp_run, "R8 late window", last_run, exp_run);
        else
            chk(last_run == exp_run, "R4 window length", last_run, exp_run);
        if (kind == 3)
            chk(n_clk - c0 == exp_clk, "R8 late pulse is clock", n_clk - c0, exp_clk);
        else if (kind == 4)
            chk(n_clk - c0 == exp_clk, "R3 level gives one pulse", n_clk - c0, exp_clk);
        else
            chk(n_clk - c0 == exp_clk, "R4 clock pulses", n_clk - c0, exp_clk);
        chk(n_data - d0 == exp_bit, "R5 data pulses", n_data - d0, exp_bit);
        chk(n_valid - v0 == exp_clk, "R7 strobes", n_valid - v0, exp_clk);
        chk(last_bit == exp_bit, "R7 recovered bit", last_bit, exp_bit);
        chk(n_both == b0, "R9 no dual pulse", n_both - b0, 0);
        chk(clk_win && !data_win, "R2 idle window", int'(clk_win), 1);
        prev_exp = exp_bit;
    endtask

    initial begin
        for (int s = 4; s <= 5; s++) begin
            for (int l = 7; l <= 8; l++) begin
                s_len = s;
                l_len = l;
                win_short = 8'(s);
                win_long = 8'(l);
                do_reset();
                for (int p = 0; p < 16; p++) begin
                    for (int i = 0; i < 4; i++) begin
                        if (((p >> i) & 1) != 0) do_cell(((i + p) % 2 != 0) ? 2 : 1);
                        else                     do_cell(0);
                    end
                end
                do_cell(1);
                do_cell(2);
                do_cell(3);
                do_cell(4);
            end
        end
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule